// File: doc/BRIEF.md
# Power Domain Sequencer

This block switches up to twelve power islands on and off in a fixed, safe order. For each island it drives four control lines: a power switch enable, a reset release, an isolation clamp and a clock gate. Each island also returns one acknowledge line from its power switch. That line is asynchronous, and the block synchronises it before use.

A pulse on an island's request line, together with the wanted level, queues a sequence for that island. The engine runs one sequence at a time and serves queued islands lowest number first. When a sequence ends, the block reports a single-cycle completion event that carries the island number and an error flag.

All settling and polling times come from a microsecond tick, made by dividing the system clock. A register window lets software read the control image and the synchronised acknowledges. Software can also clear the sticky timeout flags through the same window.

There is no back-pressure on either side. Requests are latched into a pending bitmap and are never refused. Completion events are plain status pulses with no ready signal.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset, every domain is off: clock gate 0, isolation 1, reset release 0, and power pin at its inactive level. The inactive level is 1 for a domain whose PWR_INV bit is set and 0 otherwise. After reset, busy is 0 and every register reads 0 except isolation (all ones) and power (equal to PWR_INV).
- R2: The register window is read combinationally, with bit n belonging to domain n. The offsets are: 0x18 clock gates, 0x1C isolation, 0x20 reset release, 0x24 raw power pins, 0x28 synchronised acknowledges, 0x2C sticky timeouts. Any other offset reads 0.
- R3: Power-up changes the domain's pins in this order: power active, then (after the acknowledge is seen high) reset release set, then isolation cleared, then clock gate set. No cycle changes more than one control pin across all domains.
- R4: Power-down changes the pins in this order: clock gate cleared, isolation set, reset release cleared, power inactive. The sequence then waits for the acknowledge to go low before it ends.
- R5: After a change to a reset, isolation or clock pin, the next control change comes no sooner than SETTLE_US*TICK_DIV clock cycles later.
- R6: A raw acknowledge passes through two flops. A rise on ack_raw is not visible at offset 0x28 after one clock edge and is visible after the second edge.
- R7: The acknowledge is polled once per tick. If the expected level has not been seen after ACK_POLLS polls, an error event is raised and the domain's timeout bit at 0x2C is set. The domain's control pins stay at the step where the sequence stopped.
- R8: Writing 1 to a bit at offset 0x2C clears that timeout bit. Writing 0 to a bit leaves it unchanged.
- R9: For a domain with PWR_INV set, power-on drives its power pin low and power-off drives it high.
- R10: If several domains are pending at once, their sequences run one at a time in ascending domain-number order.
- R11: A request for a domain already in the requested state completes within a few cycles with a success event and changes no pin.
- R12: Each sequence ends with exactly one single-cycle evt_valid pulse. The pulse carries evt_dom and evt_err, where evt_err is 0 for success and 1 for timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_go | input | NDOM | One-cycle pulse per domain that queues a sequence |
| req_on | input | NDOM | Wanted level sampled with req_go (1 = on) |
| ack_raw | input | NDOM | Asynchronous power-switch acknowledges |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe (only offset 0x2C is writable) |
| bus_wdata | input | NDOM | Write data |
| bus_rdata | output | NDOM | Read data for bus_addr |
| dom_pwr | output | NDOM | Power switch enable pins (polarity per PWR_INV) |
| dom_rst_rel | output | NDOM | Reset release, 1 = out of reset |
| dom_iso | output | NDOM | Isolation clamp, 1 = isolated |
| dom_clk_en | output | NDOM | Clock gate enable |
| busy | output | 1 | A sequence is in progress |
| evt_valid | output | 1 | Completion pulse |
| evt_dom | output | DOM_W | Domain of the completed sequence |
| evt_err | output | 1 | Completion was a timeout |

## Verification
A wrong step index or direction in the engine shows up at the next control change. Either a pin of the wrong kind toggles, or two pins toggle in the same cycle, and the ordered change scoreboard catches this within one cycle. A settle counter that is off by one moves a pin change earlier by about one tick, and the gap check flags it. A broken poll counter or acknowledge path shifts the error event away from its expected cycle, or makes a healthy domain report a timeout. A faulty pending or priority bitmap reorders the completion events, and the event queue reports this at the first completion.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ACT_PWR,
    ACT_ACK,
    ACT_RST,
    ACT_ISO,
    ACT_CLK
  } act_e;

  typedef enum logic [1:0] {
    E_IDLE,
    E_ACT,
    E_SETTLE,
    E_ACK
  } eng_e;

  localparam int unsigned NSTEP = 5;

  localparam logic [7:0] OFS_CLK = 8'h18;
  localparam logic [7:0] OFS_ISO = 8'h1C;
  localparam logic [7:0] OFS_RST = 8'h20;
  localparam logic [7:0] OFS_PWR = 8'h24;
  localparam logic [7:0] OFS_ACK = 8'h28;
  localparam logic [7:0] OFS_TMO = 8'h2C;

  // Step table: rising sequence and its mirror for falling
  function automatic act_e step_act(input logic up, input logic [2:0] idx);
    act_e a;
    if (up) begin
      case (idx)
        3'd0:    a = ACT_PWR;
        3'd1:    a = ACT_ACK;
        3'd2:    a = ACT_RST;
        3'd3:    a = ACT_ISO;
        default: a = ACT_CLK;
      endcase
    end else begin
      case (idx)
        3'd0:    a = ACT_CLK;
        3'd1:    a = ACT_ISO;
        3'd2:    a = ACT_RST;
        3'd3:    a = ACT_PWR;
        default: a = ACT_ACK;
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/pwrseq_tick.sv
module pwrseq_tick #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
  import pwrseq_pkg::*;
#(
  parameter int NDOM      = 12,
  parameter int SETTLE_US = 5,
  parameter int ACK_POLLS = 1000,
  localparam int DOM_W    = $clog2(NDOM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NDOM-1:0]  pend,
  input  logic [NDOM-1:0]  want_on,
  input  logic [NDOM-1:0]  ack_s,
  input  logic [NDOM-1:0]  st_clk,
  input  logic [NDOM-1:0]  st_iso,
  input  logic [NDOM-1:0]  st_rst,
  input  logic [NDOM-1:0]  st_pwr,
  output logic             take_valid,
  output logic [DOM_W-1:0] take_dom,
  output logic             op_valid,
  output act_e             op_kind,
  output logic [DOM_W-1:0] op_dom,
  output logic             op_bit,
  output logic             tick_restart,
  output logic             busy,
  output logic             evt_valid,
  output logic [DOM_W-1:0] evt_dom,
  output logic             evt_err
);
  localparam int WCW = $clog2(SETTLE_US + 1);
  localparam int PCW = $clog2(ACK_POLLS + 1);

  eng_e             state;
  logic [DOM_W-1:0] dom;
  logic             up;
  logic [2:0]       step;
  logic [WCW-1:0]   wcnt;
  logic [PCW-1:0]   pcnt;
  logic [DOM_W-1:0] low;
  logic             low_on, low_off, last_step;
  act_e             cur;

  // Lowest pending domain wins
  always_comb begin
    low = '0;
    for (int i = NDOM - 1; i >= 0; i--)
      if (pend[i]) low = DOM_W'(i);
  end

  assign low_on  = st_clk[low] & st_rst[low] & ~st_iso[low] & st_pwr[low];
  assign low_off = ~st_clk[low] & ~st_rst[low] & st_iso[low] & ~st_pwr[low];

  assign cur          = step_act(up, step);
  assign last_step    = (step == 3'(NSTEP - 1));
  assign take_valid   = (state == E_IDLE) && (|pend);
  assign take_dom     = low;
  assign op_valid     = (state == E_ACT) && (cur != ACT_ACK);
  assign op_kind      = cur;
  assign op_dom       = dom;
  assign op_bit       = (cur == ACT_ISO) ? ~up : up;
  assign tick_restart = (state == E_ACT);
  assign busy         = (state != E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= E_IDLE;
      dom       <= '0;
      up        <= 1'b0;
      step      <= '0;
      wcnt      <= '0;
      pcnt      <= '0;
      evt_valid <= 1'b0;
      evt_dom   <= '0;
      evt_err   <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      case (state)
        E_IDLE: if (|pend) begin
          dom <= low;
          up  <= want_on[low];
          if (want_on[low] ? low_on : low_off) begin
            evt_valid <= 1'b1;
            evt_dom   <= low;
            evt_err   <= 1'b0;
          end else begin
            step  <= '0;
            state <= E_ACT;
          end
        end
        E_ACT: begin
          if (cur == ACT_ACK) begin
            pcnt  <= '0;
            state <= E_ACK;
          end else if (cur == ACT_PWR) begin
            step <= step + 3'd1;
          end else begin
            wcnt  <= '0;
            state <= E_SETTLE;
          end
        end
        E_SETTLE: if (tick) begin
          if (wcnt == WCW'(SETTLE_US - 1)) begin
            if (last_step) begin
              evt_valid <= 1'b1;
              evt_dom   <= dom;
              evt_err   <= 1'b0;
              state     <= E_IDLE;
            end else begin
              step  <= step + 3'd1;
              state <= E_ACT;
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: if (tick) begin
          if (ack_s[dom] == up) begin
            if (last_step) begin
              evt_valid <= 1'b1;
              evt_dom   <= dom;
              evt_err   <= 1'b0;
              state     <= E_IDLE;
            end else begin
              step  <= step + 3'd1;
              state <= E_ACT;
            end
          end else if (pcnt == PCW'(ACK_POLLS - 1)) begin
            evt_valid <= 1'b1;
            evt_dom   <= dom;
            evt_err   <= 1'b1;
            state     <= E_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int            NDOM      = 12,
  parameter int            TICK_DIV  = 100,
  parameter int            SETTLE_US = 5,
  parameter int            ACK_POLLS = 1000,
  parameter logic [NDOM-1:0] PWR_INV = '0,
  parameter int            ADDR_W    = 8,
  localparam int           DOM_W     = $clog2(NDOM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDOM-1:0]   req_go,
  input  logic [NDOM-1:0]   req_on,
  input  logic [NDOM-1:0]   ack_raw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NDOM-1:0]   bus_wdata,
  output logic [NDOM-1:0]   bus_rdata,
  output logic [NDOM-1:0]   dom_pwr,
  output logic [NDOM-1:0]   dom_rst_rel,
  output logic [NDOM-1:0]   dom_iso,
  output logic [NDOM-1:0]   dom_clk_en,
  output logic              busy,
  output logic              evt_valid,
  output logic [DOM_W-1:0]  evt_dom,
  output logic              evt_err
);
  logic [NDOM-1:0]  clk_q, iso_q, rst_q, pwr_q, pwr_act;
  logic [NDOM-1:0]  pend_q, want_q, tmo_q, ack_s;
  logic             tick, tick_restart;
  logic             take_valid, op_valid, op_bit;
  logic [DOM_W-1:0] take_dom, op_dom;
  act_e             op_kind;
  logic             wr_tmo;

  assign pwr_act = pwr_q ^ PWR_INV;
  assign wr_tmo  = bus_we && (bus_addr == ADDR_W'(OFS_TMO));

  pwrseq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tick_restart), .tick(tick)
  );

  pwrseq_sync #(.W(NDOM)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_raw), .q(ack_s)
  );

  pwrseq_engine #(.NDOM(NDOM), .SETTLE_US(SETTLE_US), .ACK_POLLS(ACK_POLLS)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pend(pend_q), .want_on(want_q), .ack_s(ack_s),
    .st_clk(clk_q), .st_iso(iso_q), .st_rst(rst_q), .st_pwr(pwr_act),
    .take_valid(take_valid), .take_dom(take_dom),
    .op_valid(op_valid), .op_kind(op_kind), .op_dom(op_dom), .op_bit(op_bit),
    .tick_restart(tick_restart), .busy(busy),
    .evt_valid(evt_valid), .evt_dom(evt_dom), .evt_err(evt_err)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    logic hit;
    assign hit = op_valid && (op_dom == DOM_W'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_q[d] <= 1'b0;
        iso_q[d] <= 1'b1;
        rst_q[d] <= 1'b0;
        pwr_q[d] <= PWR_INV[d];
      end else if (hit) begin
        case (op_kind)
          ACT_CLK: clk_q[d] <= op_bit;
          ACT_ISO: iso_q[d] <= op_bit;
          ACT_RST: rst_q[d] <= op_bit;
          ACT_PWR: pwr_q[d] <= op_bit ^ PWR_INV[d];
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[d] <= 1'b0;
        want_q[d] <= 1'b0;
      end else if (req_go[d]) begin
        pend_q[d] <= 1'b1;
        want_q[d] <= req_on[d];
      end else if (take_valid && take_dom == DOM_W'(d)) begin
        pend_q[d] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                              tmo_q[d] <= 1'b0;
      else if (evt_valid && evt_err && evt_dom == DOM_W'(d))   tmo_q[d] <= 1'b1;
      else if (wr_tmo && bus_wdata[d])                         tmo_q[d] <= 1'b0;
    end

    // Clock only runs on a powered, released, unclamped domain
    assert_clk_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clk_q[d] |-> (rst_q[d] && !iso_q[d] && pwr_act[d]));

    // Clamp removed only after reset release; release only while powered
    assert_rst_iso_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!iso_q[d] |-> rst_q[d]) and (rst_q[d] |-> pwr_act[d]));

    // A timeout flag rises only after an error event for that domain
    assert_tmo_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmo_q[d]) |-> $past(evt_valid && evt_err && evt_dom == DOM_W'(d)));
  end

  // One control pin moves per cycle across the whole block
  assert_one_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clk_q, iso_q, rst_q, pwr_q} ^ $past({clk_q, iso_q, rst_q, pwr_q})) <= 1);

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_CLK)) bus_rdata = clk_q;
    else if (bus_addr == ADDR_W'(OFS_ISO)) bus_rdata = iso_q;
    else if (bus_addr == ADDR_W'(OFS_RST)) bus_rdata = rst_q;
    else if (bus_addr == ADDR_W'(OFS_PWR)) bus_rdata = pwr_q;
    else if (bus_addr == ADDR_W'(OFS_ACK)) bus_rdata = ack_s;
    else if (bus_addr == ADDR_W'(OFS_TMO)) bus_rdata = tmo_q;
    else                                   bus_rdata = '0;
  end

  assign dom_pwr     = pwr_q;
  assign dom_rst_rel = rst_q;
  assign dom_iso     = iso_q;
  assign dom_clk_en  = clk_q;
endmodule

// File: tb/pwrseq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrseq_ctrl_tb_top;
  localparam int ND    = 12;
  localparam int DW    = $clog2(ND);
  localparam int DIV   = 4;
  localparam int SET   = 5;
  localparam int POLLS = 40;
  localparam logic [ND-1:0] INV = 12'h0A0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [ND-1:0] req_go = '0, req_on = '0, ack_raw;
  logic [7:0]    bus_addr = 8'h00;
  logic          bus_we = 1'b0;
  logic [ND-1:0] bus_wdata = '0, bus_rdata;
  logic [ND-1:0] dom_pwr, dom_rst_rel, dom_iso, dom_clk_en;
  logic          busy, evt_valid, evt_err;
  logic [DW-1:0] evt_dom;

  pwrseq_ctrl #(.NDOM(ND), .TICK_DIV(DIV), .SETTLE_US(SET), .ACK_POLLS(POLLS),
                .PWR_INV(INV), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_on(req_on), .ack_raw(ack_raw),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dom_pwr(dom_pwr), .dom_rst_rel(dom_rst_rel), .dom_iso(dom_iso), .dom_clk_en(dom_clk_en),
    .busy(busy), .evt_valid(evt_valid), .evt_dom(evt_dom), .evt_err(evt_err)
  );

  always #5 clk = ~clk;

  // Power switch model: acknowledge follows the active power level after 3 cycles
  logic [ND-1:0] stuck = '0, force_ack = '0, a1, a2, a3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin a1 <= '0; a2 <= '0; a3 <= '0; end
    else begin a1 <= (dom_pwr ^ INV) & ~stuck; a2 <= a1; a3 <= a2; end
  end
  assign ack_raw = a3 | force_ack;

  int n_chk = 0, n_fail = 0, cyc = 0, last_evt_cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queues
  int q_cd[$], q_ck[$], q_ed[$], q_ee[$];
  logic [ND-1:0] m_clk = '0, m_iso = '1, m_rst = '0, m_pwr = '0, m_tmo = '0;

  task automatic push_chg(input int d, input int k);
    q_cd.push_back(d); q_ck.push_back(k);
  endtask

  // Kinds: 0 power, 1 reset release, 2 isolation, 3 clock gate
  task automatic push_seq(input int d, input bit up);
    if (up) begin
      if (!m_pwr[d]) begin push_chg(d, 0); m_pwr[d] = 1'b1; end
      if (stuck[d]) begin
        q_ed.push_back(d); q_ee.push_back(1); m_tmo[d] = 1'b1;
        return;
      end
      if (!m_rst[d]) begin push_chg(d, 1); m_rst[d] = 1'b1; end
      if (m_iso[d])  begin push_chg(d, 2); m_iso[d] = 1'b0; end
      if (!m_clk[d]) begin push_chg(d, 3); m_clk[d] = 1'b1; end
    end else begin
      if (m_clk[d])  begin push_chg(d, 3); m_clk[d] = 1'b0; end
      if (!m_iso[d]) begin push_chg(d, 2); m_iso[d] = 1'b1; end
      if (m_rst[d])  begin push_chg(d, 1); m_rst[d] = 1'b0; end
      if (m_pwr[d])  begin push_chg(d, 0); m_pwr[d] = 1'b0; end
    end
    q_ed.push_back(d); q_ee.push_back(0);
  endtask

  function automatic bit pin(input int k, input int d);
    case (k)
      0: return dom_pwr[d];
      1: return dom_rst_rel[d];
      2: return dom_iso[d];
      default: return dom_clk_en[d];
    endcase
  endfunction

  // Monitor: pin changes and completion events against the queues
  logic [3:0] prev [ND];
  int last_k = -1, last_c = 0;
  always @(negedge clk) begin
    for (int d = 0; d < ND; d++) begin
      for (int k = 0; k < 4; k++) begin
        if (rst_n && pin(k, d) != prev[d][k]) begin
          if (q_cd.size() == 0) chk(0, "R3 unexpected pin change", d*16+k, 0);
          else begin
            int ed, ek;
            ed = q_cd.pop_front(); ek = q_ck.pop_front();
            chk(ed == d && ek == k, "R3/R4 change order (dom*16+kind)", d*16+k, ed*16+ek);
          end
          if (last_k > 0)
            chk(cyc - last_c >= SET*DIV, "R5 settle gap", cyc - last_c, SET*DIV);
          last_k = k; last_c = cyc;
        end
        prev[d][k] = pin(k, d);
      end
    end
    if (rst_n && evt_valid) begin
      last_evt_cyc = cyc;
      if (q_ed.size() == 0) chk(0, "R12 unexpected event", int'(evt_dom), 0);
      else begin
        int ed, ee;
        ed = q_ed.pop_front(); ee = q_ee.pop_front();
        chk(int'(evt_dom) == ed && int'(evt_err) == ee, "R12 event (dom*2+err)",
            int'(evt_dom)*2 + int'(evt_err), ed*2 + ee);
      end
    end
  end

  task automatic rd(input logic [7:0] a, output logic [ND-1:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [ND-1:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic req(input logic [ND-1:0] go, input logic [ND-1:0] on);
    @(negedge clk); req_go = go; req_on = on;
    @(negedge clk); req_go = '0;
  endtask

  task automatic wait_evts();
    while (q_ed.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    logic [ND-1:0] v;
    rd(8'h18, v); chk(v == m_clk, {tag, " R2 clock reg"}, v, m_clk);
    rd(8'h1C, v); chk(v == m_iso, {tag, " R2 isolation reg"}, v, m_iso);
    rd(8'h20, v); chk(v == m_rst, {tag, " R2 reset reg"}, v, m_rst);
    rd(8'h24, v); chk(v == (m_pwr ^ INV), {tag, " R2 power reg"}, v, m_pwr ^ INV);
    rd(8'h28, v); chk(v == (m_pwr & ~stuck), {tag, " R6 ack reg"}, v, m_pwr & ~stuck);
    rd(8'h2C, v); chk(v == m_tmo, {tag, " R7 timeout reg"}, v, m_tmo);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [ND-1:0] v;
    int t0;
    repeat (5) @(negedge clk);
    // R1: reset state at the pins and registers
    chk(dom_pwr == INV && dom_iso == '1 && dom_clk_en == '0 && dom_rst_rel == '0,
        "R1 reset pins", {dom_pwr, dom_iso}, {INV, 12'hFFF});
    chk(busy == 1'b0, "R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R1");
    rd(8'h30, v); chk(v == '0, "R2 unmapped offset", v, 0);

    // R3, R5: power up domain 2
    push_seq(2, 1); req(12'h004, 12'h004); wait_evts();
    check_regs("R3");

    // R9: inverted domain 5 powers on with a low pin
    push_seq(5, 1); req(12'h020, 12'h020); wait_evts();
    chk(dom_pwr[5] == 1'b0, "R9 inverted power pin", dom_pwr[5], 0);
    check_regs("R9");

    // R10: three domains pending at once, served lowest first
    push_seq(2, 0); push_seq(3, 1); push_seq(9, 1);
    req(12'h20C, 12'h208); wait_evts();
    check_regs("R10");

    // R11: already on, completes quickly with no pin change
    push_seq(3, 1); t0 = cyc; req(12'h008, 12'h008); wait_evts();
    chk(last_evt_cyc - t0 <= 5, "R11 immediate completion", last_evt_cyc - t0, 5);

    // R7: stuck acknowledge on domain 7 times out
    stuck[7] = 1'b1;
    push_seq(7, 1); t0 = cyc; req(12'h080, 12'h080); wait_evts();
    chk(last_evt_cyc - t0 >= POLLS*DIV, "R7 timeout delay", last_evt_cyc - t0, POLLS*DIV);
    check_regs("R7");

    // R8: write-one-to-clear
    wr(8'h2C, 12'h000); rd(8'h2C, v); chk(v == 12'h080, "R8 zero write keeps", v, 12'h080);
    wr(8'h2C, 12'h001); rd(8'h2C, v); chk(v == 12'h080, "R8 other bit keeps", v, 12'h080);
    wr(8'h2C, 12'h080); m_tmo[7] = 1'b0;
    rd(8'h2C, v); chk(v == 12'h000, "R8 one write clears", v, 0);

    // R6: two-flop latency on acknowledge of idle domain 11
    @(negedge clk); force_ack[11] = 1'b1;
    @(negedge clk); #1; bus_addr = 8'h28; #1;
    chk(bus_rdata[11] == 1'b0, "R6 not visible after one edge", bus_rdata[11], 0);
    @(negedge clk); #1;
    chk(bus_rdata[11] == 1'b1, "R6 visible after two edges", bus_rdata[11], 1);
    force_ack[11] = 1'b0; repeat (4) @(negedge clk);

    // Recover domain 7, then R4: full power-down of domain 9
    push_seq(7, 0); req(12'h080, 12'h000); wait_evts();
    stuck[7] = 1'b0;
    push_seq(9, 0); req(12'h200, 12'h000); wait_evts();
    check_regs("R4");
    chk(q_cd.size() == 0, "R3 all expected changes seen", q_cd.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule